// File: doc/BRIEF.md
# Duty-Cycle Power-State Sequencer

This block decides when a battery-powered logging system sleeps and when it works. Out of reset it sits in a stop state. It requests deep sleep, selects the low-power regulator and runs from the internal oscillator. Only two events can end that state: a periodic timer alarm and activity on the serial receive line. Any other input seen while stopped changes nothing.

After a wake, the system clock is still on the internal oscillator. The sequencer first enables the PLL and waits for it to report lock. It then moves the clock select to the PLL, and only after that does it start work. An alarm wake runs one sensor measurement handshake and then one storage write handshake. A serial wake holds a dump phase open until the retrieval logic reports that it has finished.

If the PLL does not lock in time, the sequencer turns it off for one cycle and tries again. After three failed attempts it raises a sticky error flag and goes back to sleep. Every return to stop passes through an entry cycle that clears the latched wake flags, so an event from the previous active period cannot wake the system again at once.

Top module: `duty_seq_top`

## Requirements
- R1: After reset, `sleepReq`, `lpRegOn` are 1 and `clkOnPll`, `pllOn`, `senseReq`, `storeReq`, `dumpBusy`, `pllFail` are 0.
- R2: While stopped (`lpRegOn`=1), `sleepReq` is 1 and `clkOnPll`, `pllOn` and all work outputs are 0.
- R3: While stopped, `pllLocked`, `senseAck`, `storeAck` and `dumpDone` held high for any number of cycles cause no wake: `sleepReq` stays 1.
- R4: Stop is always entered through one cycle with `wakeClr`=1 and `lpRegOn`=0. A wake event that arrives during an active period, before that cycle, does not cause a wake.
- R5: On a wake, `sleepReq` falls as `pllOn` rises, and `clkOnPll` is still 0 at that point. `clkOnPll` becomes 1 only after `pllLocked` has been seen. Every rise of `senseReq` or `dumpBusy` happens with `clkOnPll`=1.
- R6: An alarm wake gives exactly one `senseReq` handshake (held until `senseAck`), then exactly one `storeReq` handshake (held until `storeAck`), then a return to stop.
- R7: A serial wake holds `dumpBusy` at 1 until `dumpDone`, then returns to stop, with no sensor or storage request.
- R8: When the alarm and serial wakes arrive in the same cycle, the order is sense, then store, then dump, then stop.
- R9: If `pllLocked` is not seen within LOCK_WAIT cycles of `pllOn`, `pllOn` drops for one cycle and the PLL is retried. After 3 failed attempts `pllFail` becomes 1 and stays 1 until reset, the system returns to stop and no work request is made.
- R10: `sleepReq` rises only in the stop-entry cycle, together with `wakeClr`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| alarmWake | input | 1 | Timer alarm event |
| rxWake | input | 1 | Serial receive activity event |
| pllLocked | input | 1 | PLL lock indication |
| senseAck | input | 1 | Sensor measurement complete |
| storeAck | input | 1 | Storage write complete |
| dumpDone | input | 1 | Retrieval logic finished |
| sleepReq | output | 1 | Deep-sleep request |
| lpRegOn | output | 1 | Low-power regulator select |
| wakeClr | output | 1 | Clear of latched wake flags (stop entry) |
| pllOn | output | 1 | PLL enable |
| clkOnPll | output | 1 | System clock select: 1 = PLL, 0 = internal oscillator |
| senseReq | output | 1 | Sensor measurement request |
| storeReq | output | 1 | Storage write request |
| dumpBusy | output | 1 | Dump phase active |
| pllFail | output | 1 | Sticky PLL lock failure flag |

## Verification
The alarm and the serial event can land on the same clock edge. The bench provokes this by pulsing both wake inputs in one cycle. It then requires the scoreboard to see sense, store and dump in that order, each with the clock already on the PLL. A second collision is a wake event that arrives while a sensor handshake is still open. It is judged at the ports: after the return to stop, `sleepReq` must stay high and no request of any kind may appear.

// File: rtl/duty_seq_pkg.sv
package duty_seq_pkg;

  typedef enum logic [2:0] {
    ST_STOP, ST_ENTER, ST_PLLWAIT, ST_PLLOFF,
    ST_CLKSW, ST_SENSE, ST_STORE, ST_DUMP
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrWake;
    logic captureJob;
    logic tmrClr;
    logic tmrRun;
    logic tryInc;
    logic setErr;
  } dpCmd_t;

  // status from datapath to control
  typedef struct packed {
    logic anyWake;
    logic alarmJob;
    logic dumpPend;
    logic tmrDone;
    logic lastTry;
  } dpStat_t;

endpackage

// File: rtl/duty_seq_dp.sv
module duty_seq_dp
  import duty_seq_pkg::*;
#(
  parameter int LOCK_WAIT = 16,
  parameter int MAX_TRIES = 3
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    alarmWake,
  input  logic    rxWake,
  input  dpCmd_t  cmd,
  output dpStat_t stat,
  output logic    pllFail
);
  localparam int TW = (LOCK_WAIT > 1) ? $clog2(LOCK_WAIT) : 1;
  localparam int NW = (MAX_TRIES > 1) ? $clog2(MAX_TRIES) : 1;

  logic          alarmSt, rxSt;
  logic          alarmJob, dumpPend;
  logic [TW-1:0] tmr;
  logic [NW-1:0] tries;
  logic          errQ;

  // sticky wake flags; the stop-entry clear takes priority over a new event
  always_ff @(posedge clk) begin
    if (!rstN || cmd.clrWake) begin
      alarmSt <= 1'b0;
      rxSt    <= 1'b0;
    end else begin
      alarmSt <= alarmSt | alarmWake;
      rxSt    <= rxSt | rxWake;
    end
  end

  // job captured at wake; tries restart on every wake
  always_ff @(posedge clk) begin
    if (!rstN) begin
      alarmJob <= 1'b0;
      dumpPend <= 1'b0;
      tries    <= '0;
    end else if (cmd.captureJob) begin
      alarmJob <= alarmSt;
      dumpPend <= rxSt;
      tries    <= '0;
    end else if (cmd.tryInc) begin
      tries <= tries + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || cmd.tmrClr) tmr <= '0;
    else if (cmd.tmrRun)     tmr <= tmr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)           errQ <= 1'b0;
    else if (cmd.setErr) errQ <= 1'b1;
  end

  assign stat.anyWake  = alarmSt | rxSt;
  assign stat.alarmJob = alarmJob;
  assign stat.dumpPend = dumpPend;
  assign stat.tmrDone  = (tmr == TW'(LOCK_WAIT - 1));
  assign stat.lastTry  = (tries == NW'(MAX_TRIES - 1));
  assign pllFail       = errQ;

endmodule

// File: rtl/duty_seq_ctrl.sv
module duty_seq_ctrl
  import duty_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    pllLocked,
  input  logic    senseAck,
  input  logic    storeAck,
  input  logic    dumpDone,
  input  dpStat_t stat,
  output dpCmd_t  cmd,
  output logic    sleepReq,
  output logic    lpRegOn,
  output logic    wakeClr,
  output logic    pllOn,
  output logic    clkOnPll,
  output logic    senseReq,
  output logic    storeReq,
  output logic    dumpBusy
);
  seqState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_STOP;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    cmd       = '0;
    unique case (state)
      ST_STOP: if (stat.anyWake) begin
        cmd.captureJob = 1'b1;
        cmd.tmrClr     = 1'b1;
        nextState      = ST_PLLWAIT;
      end
      ST_ENTER: begin
        cmd.clrWake = 1'b1;
        nextState   = ST_STOP;
      end
      ST_PLLWAIT: begin
        if (pllLocked) begin
          nextState = ST_CLKSW;
        end else if (stat.tmrDone) begin
          if (stat.lastTry) begin
            cmd.setErr = 1'b1;
            nextState  = ST_ENTER;
          end else begin
            cmd.tryInc = 1'b1;
            nextState  = ST_PLLOFF;
          end
        end else begin
          cmd.tmrRun = 1'b1;
        end
      end
      ST_PLLOFF: begin
        cmd.tmrClr = 1'b1;
        nextState  = ST_PLLWAIT;
      end
      ST_CLKSW: nextState = stat.alarmJob ? ST_SENSE : ST_DUMP;
      ST_SENSE: if (senseAck) nextState = ST_STORE;
      ST_STORE: if (storeAck) nextState = stat.dumpPend ? ST_DUMP : ST_ENTER;
      ST_DUMP:  if (dumpDone) nextState = ST_ENTER;
      default:  nextState = ST_STOP;
    endcase
  end

  assign sleepReq = (state == ST_STOP) || (state == ST_ENTER);
  assign lpRegOn  = (state == ST_STOP);
  assign wakeClr  = (state == ST_ENTER);
  assign clkOnPll = (state == ST_CLKSW) || (state == ST_SENSE) ||
                    (state == ST_STORE) || (state == ST_DUMP);
  assign pllOn    = clkOnPll || (state == ST_PLLWAIT);
  assign senseReq = (state == ST_SENSE);
  assign storeReq = (state == ST_STORE);
  assign dumpBusy = (state == ST_DUMP);

endmodule

// File: rtl/duty_seq_top.sv
module duty_seq_top
  import duty_seq_pkg::*;
#(
  parameter int LOCK_WAIT = 16,
  parameter int MAX_TRIES = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic alarmWake,
  input  logic rxWake,
  input  logic pllLocked,
  input  logic senseAck,
  input  logic storeAck,
  input  logic dumpDone,
  output logic sleepReq,
  output logic lpRegOn,
  output logic wakeClr,
  output logic pllOn,
  output logic clkOnPll,
  output logic senseReq,
  output logic storeReq,
  output logic dumpBusy,
  output logic pllFail
);
  dpCmd_t  cmd;
  dpStat_t stat;

  duty_seq_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .pllLocked(pllLocked), .senseAck(senseAck),
    .storeAck(storeAck), .dumpDone(dumpDone), .stat(stat), .cmd(cmd),
    .sleepReq(sleepReq), .lpRegOn(lpRegOn), .wakeClr(wakeClr), .pllOn(pllOn),
    .clkOnPll(clkOnPll), .senseReq(senseReq), .storeReq(storeReq),
    .dumpBusy(dumpBusy)
  );

  duty_seq_dp #(.LOCK_WAIT(LOCK_WAIT), .MAX_TRIES(MAX_TRIES)) i_dp (
    .clk(clk), .rstN(rstN), .alarmWake(alarmWake), .rxWake(rxWake),
    .cmd(cmd), .stat(stat), .pllFail(pllFail)
  );

endmodule

// File: rtl/duty_seq_chk.sv
module duty_seq_chk (
  input logic clk,
  input logic rstN,
  input logic sleepReq,
  input logic lpRegOn,
  input logic wakeClr,
  input logic pllOn,
  input logic clkOnPll,
  input logic senseReq,
  input logic storeReq,
  input logic dumpBusy,
  input logic pllFail
);
  p_stop_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    lpRegOn |-> (sleepReq && !clkOnPll && !pllOn && !senseReq && !storeReq && !dumpBusy));

  p_clear_before_stop_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lpRegOn) |-> $past(wakeClr));

  p_fast_clock_first_r5: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(senseReq) || $rose(dumpBusy)) |-> (clkOnPll && $past(clkOnPll)));

  p_wake_on_osc_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pllOn) |-> (!clkOnPll && !sleepReq));

  p_store_after_sense_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(storeReq) |-> $past(senseReq));

  p_one_job_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({senseReq, storeReq, dumpBusy}));

  p_fail_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    pllFail |=> pllFail);

  p_sleep_rise_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sleepReq) |-> wakeClr);

endmodule

bind duty_seq_top duty_seq_chk i_chk (
  .clk(clk), .rstN(rstN), .sleepReq(sleepReq), .lpRegOn(lpRegOn),
  .wakeClr(wakeClr), .pllOn(pllOn), .clkOnPll(clkOnPll), .senseReq(senseReq),
  .storeReq(storeReq), .dumpBusy(dumpBusy), .pllFail(pllFail)
);

// File: tb/test_duty_seq_top.sv
module test_duty_seq_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic alarmWake = 1'b0, rxWake = 1'b0;
  logic forceAll = 1'b0;
  logic senseAckR = 1'b0, storeAckR = 1'b0, dumpDoneR = 1'b0;
  logic pllLocked, senseAck, storeAck, dumpDone;
  logic sleepReq, lpRegOn, wakeClr, pllOn, clkOnPll;
  logic senseReq, storeReq, dumpBusy, pllFail;
  int   lockDelay = 3;
  int   lockCnt = 0;
  int   tests = 0, fails = 0;
  int   pllRises = 0;
  byte  expQ[$];

  always #2 clk = ~clk;

  // PLL model: lock after lockDelay cycles of enable
  always @(posedge clk) lockCnt <= pllOn ? lockCnt + 1 : 0;
  assign pllLocked = forceAll | (pllOn && lockCnt >= lockDelay);
  assign senseAck  = forceAll | senseAckR;
  assign storeAck  = forceAll | storeAckR;
  assign dumpDone  = forceAll | dumpDoneR;

  duty_seq_top i_duty_seq_top (
    .clk(clk), .rstN(rstN), .alarmWake(alarmWake), .rxWake(rxWake),
    .pllLocked(pllLocked), .senseAck(senseAck), .storeAck(storeAck),
    .dumpDone(dumpDone), .sleepReq(sleepReq), .lpRegOn(lpRegOn),
    .wakeClr(wakeClr), .pllOn(pllOn), .clkOnPll(clkOnPll),
    .senseReq(senseReq), .storeReq(storeReq), .dumpBusy(dumpBusy),
    .pllFail(pllFail)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  // responders
  initial forever begin
    @(negedge clk);
    if (senseReq && !forceAll) begin
      repeat (4) @(negedge clk);
      senseAckR = 1'b1; @(negedge clk); senseAckR = 1'b0;
    end
  end
  initial forever begin
    @(negedge clk);
    if (storeReq && !forceAll) begin
      repeat (2) @(negedge clk);
      storeAckR = 1'b1; @(negedge clk); storeAckR = 1'b0;
    end
  end
  initial forever begin
    @(negedge clk);
    if (dumpBusy && !forceAll) begin
      repeat (8) @(negedge clk);
      dumpDoneR = 1'b1; @(negedge clk); dumpDoneR = 1'b0;
    end
  end

  // monitor: scoreboard of work requests plus edge rules
  initial begin
    logic pS = 0, pW = 0, pD = 0, pP = 0, pL = 1, pSl = 1, pClr = 0;
    forever begin
      @(negedge clk);
      if (rstN) begin
        if (senseReq && !pS) begin
          check(expQ.size() > 0 && expQ[0] == "S", "R6", "sense request order",
                expQ.size() > 0 ? int'(expQ[0]) : 0, "S");
          check(clkOnPll, "R5", "clock on PLL at sense", clkOnPll, 1);
          if (expQ.size() > 0) void'(expQ.pop_front());
        end
        if (storeReq && !pW) begin
          check(expQ.size() > 0 && expQ[0] == "W", "R6", "store request order",
                expQ.size() > 0 ? int'(expQ[0]) : 0, "W");
          if (expQ.size() > 0) void'(expQ.pop_front());
        end
        if (dumpBusy && !pD) begin
          check(expQ.size() > 0 && expQ[0] == "D", "R7", "dump order",
                expQ.size() > 0 ? int'(expQ[0]) : 0, "D");
          check(clkOnPll, "R5", "clock on PLL at dump", clkOnPll, 1);
          if (expQ.size() > 0) void'(expQ.pop_front());
        end
        if (pllOn && !pP) begin
          pllRises++;
          check(!clkOnPll && !sleepReq, "R5", "wake starts on oscillator",
                {clkOnPll, sleepReq}, 0);
        end
        if (lpRegOn && !pL)
          check(pClr, "R4", "clear cycle before stop", pClr, 1);
        if (sleepReq && !pSl)
          check(wakeClr, "R10", "sleep request rises with clear", wakeClr, 1);
      end
      pS = senseReq; pW = storeReq; pD = dumpBusy; pP = pllOn;
      pL = lpRegOn; pSl = sleepReq; pClr = wakeClr;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  task automatic pulse(input logic a, input logic r);
    @(negedge clk); alarmWake = a; rxWake = r;
    @(negedge clk); alarmWake = 1'b0; rxWake = 1'b0;
  endtask

  task automatic waitLevel(input bit wantStop, input string req);
    int n = 0;
    while (lpRegOn != wantStop && n < 1000) begin @(negedge clk); n++; end
    check(lpRegOn == wantStop, req, "stop level reached", lpRegOn, wantStop);
  endtask

  task automatic runCycle(input logic a, input logic r, input string req);
    pulse(a, r);
    waitLevel(1'b0, req);
    waitLevel(1'b1, req);
    check(expQ.size() == 0, req, "all expected requests seen", expQ.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(sleepReq && lpRegOn, "R1", "sleep and regulator after reset",
          {sleepReq, lpRegOn}, 3);
    check(!clkOnPll && !pllOn && !senseReq && !storeReq && !dumpBusy && !pllFail,
          "R1", "idle outputs after reset",
          {clkOnPll, pllOn, senseReq, storeReq, dumpBusy, pllFail}, 0);

    // R3 other inputs do not wake
    forceAll = 1'b1;
    repeat (20) @(negedge clk);
    check(sleepReq && lpRegOn, "R3", "no wake from acks/lock", sleepReq, 1);
    check(!pllOn, "R2", "PLL off while stopped", pllOn, 0);
    forceAll = 1'b0;
    repeat (3) @(negedge clk);
    check(sleepReq, "R3", "still asleep after release", sleepReq, 1);

    // R6 alarm wake
    expQ.push_back("S"); expQ.push_back("W");
    runCycle(1'b1, 1'b0, "R6");

    // R7 serial wake
    expQ.push_back("D");
    runCycle(1'b0, 1'b1, "R7");

    // R8 both in one cycle
    expQ.push_back("S"); expQ.push_back("W"); expQ.push_back("D");
    runCycle(1'b1, 1'b1, "R8");

    // R4 stale event during active period
    expQ.push_back("S"); expQ.push_back("W");
    pulse(1'b1, 1'b0);
    while (!senseReq) @(negedge clk);
    alarmWake = 1'b1; rxWake = 1'b1; @(negedge clk);
    alarmWake = 1'b0; rxWake = 1'b0;
    waitLevel(1'b1, "R4");
    repeat (30) @(negedge clk);
    check(sleepReq && lpRegOn, "R4", "stale event gives no wake", sleepReq, 1);
    check(expQ.size() == 0, "R4", "no extra requests", expQ.size(), 0);

    // R9 lock never arrives
    lockDelay = 100;
    pllRises = 0;
    pulse(1'b1, 1'b0);
    waitLevel(1'b0, "R9");
    waitLevel(1'b1, "R9");
    check(pllRises == 3, "R9", "PLL attempts", pllRises, 3);
    check(pllFail, "R9", "fail flag set", pllFail, 1);

    // R9 flag sticky; later wake still works
    lockDelay = 3;
    expQ.push_back("S"); expQ.push_back("W");
    runCycle(1'b1, 1'b0, "R9");
    check(pllFail, "R9", "fail flag stays set", pllFail, 1);
    check(!clkOnPll && lpRegOn, "R2", "back on oscillator in stop", clkOnPll, 0);

    finish();
  end
endmodule